// File: doc/BRIEF.md
# Scatter-Gather Descriptor Table Builder

This block turns a request, given as a list of scatter-gather segments, into a table of physical region descriptors for a bus-mastering DMA engine. Each segment arrives on a valid/ready handshake as a 32-bit bus address, a byte length and a flag that marks the final segment of the request. Each descriptor is two 32-bit words. The first word is the start address. The second word holds the byte count in its low half and an end-of-table marker in bit 31.

A descriptor never spans a 64 KiB address boundary. The block walks each segment one chunk per cycle, so a segment that straddles a boundary produces one descriptor for each side of it. Some hosts decode a count field of zero as zero bytes rather than 64 KiB. For that reason, a chunk that would cover a whole aligned 64 KiB window is issued as two 32 KiB descriptors.

The newest descriptor is held back by one slot. This lets the end marker be set on it once the final segment is known to be complete. Every descriptor is counted against a fixed table capacity. If a request exceeds the capacity, the build is aborted. If a request yields no descriptors at all, that is also reported as an error. A one-cycle done pulse closes each request and carries the entry count and the error flag.

Top module: `sg_prd_builder`

## Requirements
- R1: The byte count of every descriptor is the smaller of two values: the bytes left in the segment, and 0x10000 minus the low 16 bits of the current address. Consecutive descriptors of a segment are contiguous in address, so no descriptor crosses a 64 KiB boundary.
- R2: The control word of a descriptor carries the byte count in bits 15:0. Bits 30:16 are zero.
- R3: A chunk that would cover a full aligned 64 KiB window is issued as two descriptors. The first has the chunk address and count 0x8000. The second has the address plus 0x8000 and count 0x8000.
- R4: Bit 31 of the control word is set on the final descriptor of a successful build, and on no other descriptor. It is asserted in the same cycle as the done pulse.
- R5: A zero-length segment produces no descriptors. A zero-length final segment still closes the request and marks the preceding descriptor as final.
- R6: A request that needs more descriptors than TABLE_DEPTH is aborted. Its done pulse comes with the error flag set and an entry count of zero, and no descriptor of that request carries the end marker.
- R7: A request whose segments are all zero length ends with the error flag set and an entry count of zero.
- R8: Each request ends with exactly one single-cycle done pulse. On success, the entry count equals the number of descriptors emitted, and a request of exactly TABLE_DEPTH descriptors succeeds.
- R9: After reset, seg_ready is high, no descriptor is valid, done and error are low, and the entry count is zero. A reset in the middle of a request discards that request.
- R10: A segment is accepted only in a cycle with seg_valid and seg_ready both high. seg_ready then stays low while that segment is being walked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| seg_valid | input | 1 | Segment offered |
| seg_ready | output | 1 | Block can accept a segment |
| seg_addr | input | 32 | Segment start bus address |
| seg_len | input | LEN_W | Segment length in bytes |
| seg_last | input | 1 | Segment is the last of the request |
| desc_valid | output | 1 | Descriptor words valid this cycle |
| desc_addr | output | 32 | Descriptor address word |
| desc_ctrl | output | 32 | Descriptor control word: count in 15:0, end marker in 31 |
| entry_count | output | CNT_W | Descriptors in the last finished table, zero on error |
| build_done | output | 1 | One-cycle pulse closing a request |
| build_err | output | 1 | With build_done: overflow or empty table |

## Verification
The capacity abort is the hardest case to reach from the ports, because it takes a request whose chunk count exceeds the table depth. The bench therefore builds the block with a depth of 8 entries. One 0x50000-byte segment then needs ten descriptors, and one 0x40000-byte segment fills the table exactly, so both sides of the limit are covered. A single table of requests also places the aligned full-window split, the unaligned 64 KiB run and the zero-length final segment next to ordinary segments. Every result is compared against a software walk of the same segments.

// File: rtl/sgp_pkg.sv
// Shared types and constants for the descriptor table builder.
// Assumes 32-bit bus addresses and 16-bit descriptor count fields.
package sgp_pkg;
    localparam int ADDR_W   = 32;
    localparam int CNT_FW   = 16;
    localparam int END_BIT  = 31;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [CNT_FW-1:0] cnt;
    } sgp_desc_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WALK,
        ST_FLUSH
    } sgp_state_e;
endpackage

// File: rtl/sgp_chunker.sv
// Combinational chunk sizer: bytes to the next 64 KiB boundary, limited
// to the remaining length; a full window is cut to 32 KiB so that the
// following step yields the matching second half.
// Assumes LEN_W >= 17.
module sgp_chunker #(
    parameter int LEN_W = 32
) (
    input  logic [31:0]      addr_i,
    input  logic [LEN_W-1:0] rem_i,
    output logic [16:0]      take_o,
    output logic             rem_zero_o,
    output logic             seg_end_o
);
    localparam logic [16:0] WINDOW = 17'h10000;
    localparam logic [16:0] HALF   = 17'h08000;
    localparam int PAD = LEN_W - 17;

    logic [16:0] avail;
    logic [16:0] raw;

    // size the chunk that the current address and remaining length allow
    always_comb begin
        avail = WINDOW - {1'b0, addr_i[15:0]};
        raw   = (rem_i < {{PAD{1'b0}}, avail}) ? rem_i[16:0] : avail;
        take_o = (raw == WINDOW) ? HALF : raw;
        rem_zero_o = (rem_i == '0);
        seg_end_o  = (rem_i == {{PAD{1'b0}}, take_o});
    end
endmodule

// File: rtl/sgp_cap_counter.sv
// Counts descriptors built for the current table and flags when the
// table is full. Assumes clr and inc are never high together.
module sgp_cap_counter #(
    parameter int DEPTH = 256,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          inc_i,
    output logic [CW-1:0] count_o,
    output logic          at_cap_o
);
    // track the number of descriptors stored for this table
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) count_o <= '0;
        else if (inc_i)      count_o <= count_o + 1'b1;
    end

    assign at_cap_o = (count_o == CW'(DEPTH));
endmodule

// File: rtl/sgp_hold_slot.sv
// One-deep hold slot: a new descriptor pushes the held one out; a final
// release emits the held one with the end marker; drop discards it.
// Assumes load, release and drop are mutually exclusive.
module sgp_hold_slot
    import sgp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  sgp_desc_t        new_i,
    input  logic             final_i,
    input  logic             drop_i,
    output logic             out_valid_o,
    output logic [31:0]      out_addr_o,
    output logic [31:0]      out_ctrl_o
);
    sgp_desc_t held;
    logic      held_v;

    // keep the newest descriptor back until the next one or the end
    always_ff @(posedge clk) begin
        if (!rst_n || drop_i) held_v <= 1'b0;
        else if (load_i)      held_v <= 1'b1;
        else if (final_i)     held_v <= 1'b0;
        if (load_i) held <= new_i;
    end

    // register the outgoing descriptor words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid_o <= 1'b0;
            out_addr_o  <= '0;
            out_ctrl_o  <= '0;
        end else begin
            out_valid_o <= held_v && !drop_i && (load_i || final_i);
            out_addr_o  <= held.addr;
            out_ctrl_o  <= {final_i && !load_i, 15'd0, held.cnt};
        end
    end
endmodule

// File: rtl/sg_prd_builder.sv
// Descriptor table builder: takes segments on a valid/ready handshake,
// walks each one chunk per cycle and emits descriptors through a hold
// slot so the last one can carry the end marker. Counts entries against
// TABLE_DEPTH and aborts on overflow. Assumes LEN_W >= 17.
module sg_prd_builder
    import sgp_pkg::*;
#(
    parameter int TABLE_DEPTH = 256,
    parameter int LEN_W = 32,
    localparam int CNT_W = $clog2(TABLE_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             seg_valid,
    output logic             seg_ready,
    input  logic [31:0]      seg_addr,
    input  logic [LEN_W-1:0] seg_len,
    input  logic             seg_last,
    output logic             desc_valid,
    output logic [31:0]      desc_addr,
    output logic [31:0]      desc_ctrl,
    output logic [CNT_W-1:0] entry_count,
    output logic             build_done,
    output logic             build_err
);
    sgp_state_e       state;
    logic [31:0]      cur_addr;
    logic [LEN_W-1:0] rem_len;
    logic             cur_last;
    logic             aborted;

    logic [16:0]      take;
    logic             rem_zero, seg_end;
    logic [CNT_W-1:0] built;
    logic             at_cap;
    logic             produce, ovf_hit, load, seg_fin, flush;
    sgp_desc_t        new_desc;

    sgp_chunker #(.LEN_W(LEN_W)) chunk_i (
        .addr_i(cur_addr), .rem_i(rem_len),
        .take_o(take), .rem_zero_o(rem_zero), .seg_end_o(seg_end)
    );

    sgp_cap_counter #(.DEPTH(TABLE_DEPTH)) cap_i (
        .clk(clk), .rst_n(rst_n), .clr_i(flush), .inc_i(load),
        .count_o(built), .at_cap_o(at_cap)
    );

    sgp_hold_slot hold_i (
        .clk(clk), .rst_n(rst_n), .load_i(load), .new_i(new_desc),
        .final_i(flush && !aborted), .drop_i(ovf_hit),
        .out_valid_o(desc_valid), .out_addr_o(desc_addr), .out_ctrl_o(desc_ctrl)
    );

    // decode this cycle's walk actions
    always_comb begin
        produce  = (state == ST_WALK) && !aborted && !rem_zero;
        ovf_hit  = produce && at_cap;
        load     = produce && !at_cap;
        seg_fin  = (state == ST_WALK) && (aborted || rem_zero || ovf_hit || seg_end);
        flush    = (state == ST_FLUSH);
        seg_ready = (state == ST_IDLE);
        new_desc.addr = cur_addr;
        new_desc.cnt  = take[15:0];
    end

    // sequence segments, walk chunks and track the abort condition
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cur_addr <= '0;
            rem_len  <= '0;
            cur_last <= 1'b0;
            aborted  <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (seg_valid) begin
                    cur_addr <= seg_addr;
                    rem_len  <= seg_len;
                    cur_last <= seg_last;
                    state    <= ST_WALK;
                end
                ST_WALK: begin
                    if (ovf_hit) aborted <= 1'b1;
                    if (load) begin
                        cur_addr <= cur_addr + {15'd0, take};
                        rem_len  <= rem_len - {{(LEN_W-17){1'b0}}, take};
                    end
                    if (seg_fin) state <= cur_last ? ST_FLUSH : ST_IDLE;
                end
                default: begin
                    aborted <= 1'b0;
                    state   <= ST_IDLE;
                end
            endcase
        end
    end

    // report the close of each request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            build_done  <= 1'b0;
            build_err   <= 1'b0;
            entry_count <= '0;
        end else begin
            build_done <= flush;
            build_err  <= flush && (aborted || built == '0);
            if (flush) entry_count <= aborted ? '0 : built;
        end
    end
endmodule

// File: rtl/sgp_builder_chk.sv
// Port-level properties of the descriptor table builder, bound to it.
module sgp_builder_chk #(
    parameter int DEPTH = 256,
    parameter int CW = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          seg_valid,
    input logic          seg_ready,
    input logic          desc_valid,
    input logic [31:0]   desc_addr,
    input logic [31:0]   desc_ctrl,
    input logic [CW-1:0] entry_count,
    input logic          build_done,
    input logic          build_err
);
    a_r1_no_cross: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid |-> (desc_ctrl[15:0] != 16'd0) &&
        (({1'b0, desc_addr[15:0]} + {1'b0, desc_ctrl[15:0]}) <= 17'h10000));

    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid |-> desc_ctrl[30:16] == 15'd0);

    a_r4_marker_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_valid && desc_ctrl[31]) |-> (build_done && !build_err));

    a_r6_err_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
        build_err |-> (build_done && entry_count == '0));

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        build_done |=> !build_done);

    a_r8_count_in_cap: assert property (@(posedge clk) disable iff (!rst_n)
        build_done |-> entry_count <= CW'(DEPTH));

    a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_valid && seg_ready) |=> !seg_ready);
endmodule

bind sg_prd_builder sgp_builder_chk #(.DEPTH(TABLE_DEPTH), .CW(CNT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .seg_valid(seg_valid), .seg_ready(seg_ready),
    .desc_valid(desc_valid), .desc_addr(desc_addr), .desc_ctrl(desc_ctrl),
    .entry_count(entry_count), .build_done(build_done), .build_err(build_err)
);

// File: tb/sg_prd_builder_tb_top.sv
`timescale 1ns/1ps
module sg_prd_builder_tb_top;
    localparam int DEPTH = 8;
    localparam int CW = $clog2(DEPTH + 1);
    localparam int NSEG = 15;
    // {addr, len, last}
    localparam logic [64:0] SEGS [NSEG] = '{
        {32'h1000_0000, 32'h0000_0200, 1'b1},
        {32'h0000_FF00, 32'h0000_0300, 1'b1},
        {32'h0002_0000, 32'h0001_0000, 1'b1},
        {32'h3000_0010, 32'h0000_0020, 1'b0},
        {32'h4000_0000, 32'h0000_0000, 1'b0},
        {32'h5000_FFFE, 32'h0000_0004, 1'b1},
        {32'h0001_8000, 32'h0001_0000, 1'b1},
        {32'h0006_0000, 32'h0001_8000, 1'b1},
        {32'h0000_0100, 32'h0000_0010, 1'b0},
        {32'h0000_0000, 32'h0000_0000, 1'b1},
        {32'h0070_0000, 32'h0000_0000, 1'b1},
        {32'h0080_0000, 32'h0004_0000, 1'b1},
        {32'h0090_0000, 32'h0005_0000, 1'b1},
        {32'h00A0_1234, 32'h0000_0020, 1'b1},
        {32'h00AF_FFF0, 32'h0002_0000, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic seg_valid = 1'b0;
    logic [31:0] seg_addr = '0;
    logic [31:0] seg_len = '0;
    logic seg_last = 1'b0;
    logic seg_ready, desc_valid, build_done, build_err;
    logic [31:0] desc_addr, desc_ctrl;
    logic [CW-1:0] entry_count;

    int n_tests = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [31:0] got_addr [64];
    logic [31:0] got_ctrl [64];
    int got_n = 0;
    bit got_done = 1'b0;
    bit got_err = 1'b0;
    int got_cnt = 0;

    logic [31:0] exp_addr [64];
    logic [31:0] exp_ctrl [64];
    int exp_n;

    always #4 clk = ~clk;

    sg_prd_builder #(.TABLE_DEPTH(DEPTH), .LEN_W(32)) dut_i (
        .clk(clk), .rst_n(rst_n), .seg_valid(seg_valid), .seg_ready(seg_ready),
        .seg_addr(seg_addr), .seg_len(seg_len), .seg_last(seg_last),
        .desc_valid(desc_valid), .desc_addr(desc_addr), .desc_ctrl(desc_ctrl),
        .entry_count(entry_count), .build_done(build_done), .build_err(build_err)
    );

    // record descriptors and completions away from the active edge
    always @(negedge clk) begin
        if (rst_n && desc_valid && got_n < 64) begin
            got_addr[got_n] = desc_addr;
            got_ctrl[got_n] = desc_ctrl;
            got_n = got_n + 1;
        end
        if (rst_n && build_done) begin
            got_done = 1'b1;
            got_err  = build_err;
            got_cnt  = int'(entry_count);
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", tag, what, act, exp);
        end
    endtask

    task automatic clear_got();
        got_n = 0;
        got_done = 1'b0;
        got_err = 1'b0;
        got_cnt = -1;
    endtask

    task automatic send_seg(input logic [31:0] a, input logic [31:0] l, input logic last);
        @(negedge clk);
        seg_addr = a; seg_len = l; seg_last = last; seg_valid = 1'b1;
        while (!seg_ready) @(negedge clk);
        @(negedge clk);
        seg_valid = 1'b0;
    endtask

    task automatic wait_done();
        int k = 0;
        while (!got_done && k < 3000) begin
            @(negedge clk);
            k++;
        end
        @(negedge clk);
    endtask

    // software walk of segments first..last into the expected table
    task automatic build_model(input int first, input int last);
        exp_n = 0;
        for (int s = first; s <= last; s++) begin
            logic [31:0] a;
            logic [31:0] l;
            logic [31:0] span;
            logic [31:0] t;
            a = SEGS[s][64:33];
            l = SEGS[s][32:1];
            while (l != 0) begin
                span = 32'h10000 - {16'd0, a[15:0]};
                t = (l < span) ? l : span;
                if (t == 32'h10000) begin
                    if (exp_n < 63) begin
                        exp_addr[exp_n] = a;          exp_ctrl[exp_n] = 32'h8000;
                        exp_addr[exp_n+1] = a + 32'h8000; exp_ctrl[exp_n+1] = 32'h8000;
                    end
                    exp_n += 2;
                end else begin
                    if (exp_n < 64) begin
                        exp_addr[exp_n] = a; exp_ctrl[exp_n] = t;
                    end
                    exp_n += 1;
                end
                a = a + t;
                l = l - t;
            end
        end
        if (exp_n > 0 && exp_n <= DEPTH) exp_ctrl[exp_n-1][31] = 1'b1;
    endtask

    task automatic check_req(input int first, input int last);
        bit has_zero = 1'b0;
        bit marker = 1'b0;
        string ctag;
        build_model(first, last);
        for (int s = first; s <= last; s++)
            if (SEGS[s][32:1] == 32'd0) has_zero = 1'b1;
        chk(got_done, "R8", "done pulse seen", 32'(got_done), 32'd1);
        if (exp_n == 0 || exp_n > DEPTH) begin
            ctag = (exp_n == 0) ? "R7" : "R6";
            chk(got_err, ctag, "error flag", 32'(got_err), 32'd1);
            chk(got_cnt == 0, ctag, "entry count on error", 32'(got_cnt), 32'd0);
            for (int i = 0; i < got_n; i++) if (got_ctrl[i][31]) marker = 1'b1;
            chk(!marker, "R6", "no end marker on failed build", 32'(marker), 32'd0);
        end else begin
            chk(!got_err, "R8", "no error", 32'(got_err), 32'd0);
            chk(got_n == exp_n, has_zero ? "R5" : "R8", "descriptor total",
                32'(got_n), 32'(exp_n));
            chk(got_cnt == exp_n, "R8", "entry count", 32'(got_cnt), 32'(exp_n));
            for (int i = 0; i < got_n && i < exp_n; i++) begin
                chk(got_addr[i] == exp_addr[i], "R1", "address word", got_addr[i], exp_addr[i]);
                if (i == exp_n - 1) ctag = "R4";
                else if (exp_ctrl[i][15:0] == 16'h8000) ctag = "R3";
                else ctag = "R2";
                chk(got_ctrl[i] == exp_ctrl[i], ctag, "control word", got_ctrl[i], exp_ctrl[i]);
            end
        end
    endtask

    // watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int first;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: state after reset
        chk(seg_ready == 1'b1, "R9", "ready after reset", 32'(seg_ready), 32'd1);
        chk(desc_valid == 1'b0, "R9", "no descriptor after reset", 32'(desc_valid), 32'd0);
        chk(build_done == 1'b0 && build_err == 1'b0, "R9", "done/err after reset",
            {30'd0, build_done, build_err}, 32'd0);
        chk(entry_count == '0, "R9", "entry count after reset", 32'(entry_count), 32'd0);

        // table of requests walked by one loop
        first = 0;
        clear_got();
        for (int i = 0; i < NSEG; i++) begin
            send_seg(SEGS[i][64:33], SEGS[i][32:1], SEGS[i][0]);
            if (SEGS[i][0]) begin
                wait_done();
                check_req(first, i);
                first = i + 1;
                clear_got();
            end
        end

        // R10: ready drops while a long segment is walked
        @(negedge clk);
        seg_addr = 32'h00D0_0000; seg_len = 32'h0001_0000; seg_last = 1'b1; seg_valid = 1'b1;
        @(negedge clk);
        seg_valid = 1'b0;
        chk(seg_ready == 1'b0, "R10", "ready low while walking", 32'(seg_ready), 32'd0);
        wait_done();
        chk(got_n == 2 && got_cnt == 2, "R10", "segment taken once",
            32'(got_n), 32'd2);
        clear_got();

        // R9: reset in the middle of a request discards it
        @(negedge clk);
        seg_addr = 32'h00E0_0000; seg_len = 32'h0010_0000; seg_last = 1'b1; seg_valid = 1'b1;
        @(negedge clk);
        seg_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(seg_ready == 1'b1 && desc_valid == 1'b0, "R9", "idle after mid-walk reset",
            {30'd0, seg_ready, desc_valid}, 32'h2);
        chk(entry_count == '0, "R9", "count cleared by reset", 32'(entry_count), 32'd0);
        clear_got();
        send_seg(32'h00C0_0040, 32'h0000_0010, 1'b1);
        wait_done();
        chk(got_n == 1 && got_ctrl[0] == 32'h8000_0010, "R9", "clean build after reset",
            got_ctrl[0], 32'h8000_0010);
        chk(got_cnt == 1 && !got_err, "R9", "count after reset build", 32'(got_cnt), 32'd1);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule